// File: doc/BRIEF.md
# Periodic Sync Pulse Generator

This block drives a set of sync channels (two by default) from a free-running system time value. Each channel is armed by writing its start time. It fires once system time has reached that start time, and then re-fires every cycle period, because the start time moves forward by the period after each firing. A period of zero arms the channel for a single pulse only. One shared length register sets how long each pulse lasts, counted in clock ticks. A length of zero switches every channel to acknowledged mode. In that mode the output rises and stays high until software reads that channel's status.

Every firing also produces a one-clock event strobe. Downstream logic uses this strobe for interrupt generation, output-update and input-latch timing. The strobe appears whether or not the channel is routed to its pin. A configuration register sets three things for each channel: whether it drives its external pin, whether its sticky status feeds the event request bits and the interrupt line, and whether the channel is powered at all. The pins stay undriven (output enable low) until the configuration-loaded input rises.

Top module: `sync_pulse_gen`

## Requirements
- R1: While reset is held and right after it, all outputs are 0, including output enables, status and the interrupt line.
- R2: A write to a channel's start time arms that channel. An armed, powered channel fires at a clock edge where unsigned system time is greater than or equal to its start time. The pulse and the event strobe become visible right after that edge.
- R3: After each firing the start time advances by the channel's cycle period. A cycle period of 0 disarms the channel, so it gives a single shot.
- R4: With a nonzero length L, the level stays high for exactly L clocks. A new firing while the level is high reloads the count.
- R5: With length 0 (acknowledged mode), the level stays high until a status read strobe for that channel. The level clears on the clock after the strobe, unless the channel fires on that same clock.
- R6: The event strobe `evt_o[c]` is one clock wide for each firing and coincides with the rising edge of the level. It does not depend on the pin-enable or interrupt bits.
- R7: A sticky status bit per channel is set by each firing and cleared by that channel's status read strobe. When both happen on the same clock, the set wins.
- R8: `sync_oe_o[c]` equals pin-enable[c] AND `cfg_loaded_i`. `sync_o[c]` is the level gated by that same enable.
- R9: `evt_req_o[c]` is status[c] AND irq-enable[c]. `irq_o` is the OR of all `evt_req_o` bits.
- R10: A channel whose power bit is 0 fires no pulse and no event strobe. Its level drops on the next clock.
- R11: Register map for writes, at address `wr_addr_i`. Address 0 is configuration: bits [N-1:0] are pin enables, [2N-1:N] are irq enables, [3N-1:2N] are power enables. With N=2 these are bits 0-1, 2-3 and 4-5. Address 1 is the pulse length (low 16 bits). Address 2+2c is the start time of channel c. Address 3+2c is the cycle period of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_time_i | input | TIME_W | Free-running system time |
| cfg_loaded_i | input | 1 | Configuration loaded; allows the pins to be driven |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | TIME_W | Register write data |
| stat_rd_i | input | N_CH | Per-channel status read strobe (clears status, acknowledges) |
| sync_o | output | N_CH | Sync pin values |
| sync_oe_o | output | N_CH | Sync pin output enables (0 = high impedance) |
| evt_o | output | N_CH | One-clock internal event strobes |
| status_o | output | N_CH | Sticky per-channel pulse status |
| evt_req_o | output | N_CH | Event request bits for mapped channels |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: two channels, 32-bit time and a 16-bit length. Two channels are enough to show that per-channel routing, power and acknowledgement do not leak between channels. The random phase draws lengths from 0 to 6 and periods from 0 to 25. This keeps refiring during a live pulse, same-clock set and clear of status, and acknowledged mode on a periodic channel all within a few thousand clocks. Directed runs freeze system time so that the number of firings and the pulse width can be counted exactly.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int unsigned ADDR_CFG = 0;
  localparam int unsigned ADDR_LEN = 1;
  localparam int unsigned ADDR_CH0 = 2;

  function automatic int unsigned start_addr(int unsigned ch);
    return ADDR_CH0 + 2 * ch;
  endfunction

  function automatic int unsigned period_addr(int unsigned ch);
    return ADDR_CH0 + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/sync_regs.sv
module sync_regs #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TIME_W-1:0] wr_data_i,
  output logic [N_CH-1:0]   pin_en_o,
  output logic [N_CH-1:0]   irq_en_o,
  output logic [N_CH-1:0]   pwr_en_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [N_CH-1:0]   wr_start_o,
  output logic [N_CH-1:0]   wr_period_o
);
  import sync_pkg::*;
  localparam int unsigned CFG_W = 3 * N_CH;

  logic [CFG_W-1:0] cfg_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      len_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_CFG)) cfg_q <= wr_data_i[CFG_W-1:0];
      if (wr_addr_i == ADDR_W'(ADDR_LEN)) len_q <= wr_data_i[LEN_W-1:0];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_dec
    assign wr_start_o[c]  = wr_en_i && (wr_addr_i == ADDR_W'(start_addr(c)));
    assign wr_period_o[c] = wr_en_i && (wr_addr_i == ADDR_W'(period_addr(c)));
  end

  assign pin_en_o = cfg_q[N_CH-1:0];
  assign irq_en_o = cfg_q[2*N_CH-1:N_CH];
  assign pwr_en_o = cfg_q[3*N_CH-1:2*N_CH];
  assign len_o    = len_q;
endmodule

// File: rtl/sync_channel.sv
module sync_channel #(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic              pwr_en_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wr_start_i,
  input  logic              wr_period_i,
  input  logic [TIME_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic              fire_o,
  output logic              lvl_o,
  output logic              evt_o,
  output logic              status_o
);
  logic [TIME_W-1:0] start_q, period_q;
  logic              armed_q, lvl_q, evt_q, status_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              ack_mode;

  assign ack_mode = (len_i == '0);
  assign fire_o   = pwr_en_i && armed_q && (sys_time_i >= start_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      period_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (wr_period_i) period_q <= wr_data_i;
      if (wr_start_i) begin
        start_q <= wr_data_i;
        armed_q <= 1'b1;
      end else if (fire_o) begin
        if (period_q == '0) armed_q <= 1'b0;
        else                start_q <= start_q + period_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (!pwr_en_i) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (fire_o) begin
      lvl_q <= 1'b1;
      cnt_q <= len_i - 1'b1;
      evt_q <= 1'b1;
    end else begin
      evt_q <= 1'b0;
      if (lvl_q) begin
        if (ack_mode) begin
          if (ack_i) lvl_q <= 1'b0;
        end else if (cnt_q == '0) begin
          lvl_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_q <= 1'b0;
    else if (fire_o) status_q <= 1'b1;
    else if (ack_i)  status_q <= 1'b0;
  end

  assign lvl_o    = lvl_q;
  assign evt_o    = evt_q;
  assign status_o = status_q;
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned ADDR_W = $clog2(2 + 2 * N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic              cfg_loaded_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TIME_W-1:0] wr_data_i,
  input  logic [N_CH-1:0]   stat_rd_i,
  output logic [N_CH-1:0]   sync_o,
  output logic [N_CH-1:0]   sync_oe_o,
  output logic [N_CH-1:0]   evt_o,
  output logic [N_CH-1:0]   status_o,
  output logic [N_CH-1:0]   evt_req_o,
  output logic              irq_o
);
  logic [N_CH-1:0]  pin_en, irq_en, pwr_en, wr_start, wr_period;
  logic [N_CH-1:0]  fire, lvl;
  logic [LEN_W-1:0] len_q;

  sync_regs #(
    .N_CH(N_CH), .TIME_W(TIME_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pin_en_o   (pin_en),
    .irq_en_o   (irq_en),
    .pwr_en_o   (pwr_en),
    .len_o      (len_q),
    .wr_start_o (wr_start),
    .wr_period_o(wr_period)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    sync_channel #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sys_time_i (sys_time_i),
      .pwr_en_i   (pwr_en[c]),
      .len_i      (len_q),
      .wr_start_i (wr_start[c]),
      .wr_period_i(wr_period[c]),
      .wr_data_i  (wr_data_i),
      .ack_i      (stat_rd_i[c]),
      .fire_o     (fire[c]),
      .lvl_o      (lvl[c]),
      .evt_o      (evt_o[c]),
      .status_o   (status_o[c])
    );
  end

  assign sync_oe_o = pin_en & {N_CH{cfg_loaded_i}};
  assign sync_o    = lvl & sync_oe_o;
  assign evt_req_o = status_o & irq_en;
  assign irq_o     = |evt_req_o;
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk #(
  parameter int unsigned N_CH  = 2,
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_loaded_i,
  input logic [N_CH-1:0]  stat_rd_i,
  input logic [N_CH-1:0]  sync_oe_o,
  input logic [N_CH-1:0]  evt_o,
  input logic [N_CH-1:0]  status_o,
  input logic [N_CH-1:0]  lvl,
  input logic [N_CH-1:0]  fire,
  input logic [N_CH-1:0]  pwr_en,
  input logic [LEN_W-1:0] len_q
);
  p_oe_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_loaded_i |-> (sync_oe_o == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_a
    p_rise_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lvl[c]) |-> evt_o[c]);
    p_status_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[c] |-> status_o[c]);
    p_status_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd_i[c] && !fire[c]) |=> !status_o[c]);
    p_ack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_en[c] && len_q == '0 && lvl[c] && !stat_rd_i[c]) |=> lvl[c]);
    p_ack_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_en[c] && len_q == '0 && lvl[c] && stat_rd_i[c] && !fire[c]) |=> !lvl[c]);
    p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_en[c] |=> (!evt_o[c] && !lvl[c]));
  end
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.N_CH(N_CH), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_loaded_i(cfg_loaded_i),
  .stat_rd_i   (stat_rd_i),
  .sync_oe_o   (sync_oe_o),
  .evt_o       (evt_o),
  .status_o    (status_o),
  .lvl         (lvl),
  .fire        (fire),
  .pwr_en      (pwr_en),
  .len_q       (len_q)
);

// File: tb/sim_sync_pulse_gen.sv
`timescale 1ns/1ps
module sim_sync_pulse_gen;
  localparam int N = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] st_time = 32'd100;
  logic        loaded = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] rd = '0;
  logic [N-1:0] sync, oe, evt, status, evt_req;
  logic        irq;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sync_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_time_i(st_time), .cfg_loaded_i(loaded),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .stat_rd_i(rd),
    .sync_o(sync), .sync_oe_o(oe), .evt_o(evt), .status_o(status),
    .evt_req_o(evt_req), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [5:0]  m_cfg;
  logic [15:0] m_len;
  logic [31:0] m_start [N];
  logic [31:0] m_per [N];
  logic [15:0] m_cnt [N];
  logic [N-1:0] m_arm, m_lvl, m_evt, m_st;

  function automatic logic [N-1:0] pin_bits();  return m_cfg[1:0]; endfunction
  function automatic logic [N-1:0] irq_bits();  return m_cfg[3:2]; endfunction
  function automatic logic [N-1:0] pwr_bits();  return m_cfg[5:4]; endfunction
  function automatic logic [N-1:0] exp_oe();    return pin_bits() & {N{loaded}}; endfunction
  function automatic logic [N-1:0] exp_sync();  return m_lvl & exp_oe(); endfunction
  function automatic logic [N-1:0] exp_req();   return m_st & irq_bits(); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '0; m_len = '0; m_arm = '0; m_lvl = '0; m_evt = '0; m_st = '0;
      for (int c = 0; c < N; c++) begin
        m_start[c] = '0; m_per[c] = '0; m_cnt[c] = '0;
      end
    end else begin
      logic [N-1:0] f;
      for (int c = 0; c < N; c++)
        f[c] = pwr_bits()[c] && m_arm[c] && (st_time >= m_start[c]);
      for (int c = 0; c < N; c++) begin
        if (!pwr_bits()[c]) begin
          m_lvl[c] = 0; m_cnt[c] = 0; m_evt[c] = 0;
        end else if (f[c]) begin
          m_lvl[c] = 1; m_cnt[c] = m_len - 16'd1; m_evt[c] = 1;
        end else begin
          m_evt[c] = 0;
          if (m_lvl[c]) begin
            if (m_len == 0) begin
              if (rd[c]) m_lvl[c] = 0;
            end else if (m_cnt[c] == 0) m_lvl[c] = 0;
            else m_cnt[c] = m_cnt[c] - 16'd1;
          end
        end
        if (f[c]) m_st[c] = 1;
        else if (rd[c]) m_st[c] = 0;
        if (wr_en && wr_addr == 3'(2 + 2 * c)) begin
          m_start[c] = wr_data; m_arm[c] = 1;
        end else if (f[c]) begin
          if (m_per[c] == 0) m_arm[c] = 0;
          else m_start[c] = m_start[c] + m_per[c];
        end
        if (wr_en && wr_addr == 3'(3 + 2 * c)) m_per[c] = wr_data;
      end
      if (wr_en && wr_addr == 3'd0) m_cfg = wr_data[5:0];
      if (wr_en && wr_addr == 3'd1) m_len = wr_data[15:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 sync_oe", 32'(oe), 32'(exp_oe()));
      chk("R4/R5 sync level", 32'(sync), 32'(exp_sync()));
      chk("R6 event strobe", 32'(evt), 32'(m_evt));
      chk("R7 status", 32'(status), 32'(m_st));
      chk("R9 evt_req", 32'(evt_req), 32'(exp_req()));
      chk("R9 irq", 32'(irq), 32'(|exp_req()));
    end
  end

  int n_evt0, n_evt1, n_hi0;

  task automatic tick(input bit adv);
    @(posedge clk); #2;
    n_evt0 += int'(evt[0]);
    n_evt1 += int'(evt[1]);
    n_hi0  += int'(sync[0]);
    if (adv) st_time++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick(0);
    wr_en = 0;
  endtask

  task automatic clr_counts();
    n_evt0 = 0; n_evt1 = 0; n_hi0 = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset sync_oe", 32'(oe), 0);
    chk("R1 reset sync", 32'(sync), 0);
    chk("R1 reset status/irq", 32'({status, evt_req, irq}), 0);
    rst_n = 1;
    loaded = 1;
    tick(1);
    chk("R1 after reset evt", 32'(evt), 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      wr_en = 0; rd = '0;
      if ($urandom_range(0, 7) == 0) begin
        int sel;
        sel = $urandom_range(0, 5);
        wr_en = 1; wr_addr = 3'(sel);
        case (sel)
          0: wr_data = 32'($urandom_range(0, 63)) | 32'h30;
          1: wr_data = 32'($urandom_range(0, 6));
          2, 4: wr_data = st_time + 32'($urandom_range(0, 30));
          default: wr_data = ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom_range(1, 25));
        endcase
        if (sel == 0 && $urandom_range(0, 5) == 0) wr_data[5:4] = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 5) == 0) rd = N'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) loaded = ~loaded;
      if ($urandom_range(0, 49) == 0) st_time = st_time + 32'($urandom_range(0, 40));
      tick(1);
    end
    wr_en = 0; rd = '0; loaded = 1;

    // R3/R4/R11 periodic: length 2, period 10, time frozen during setup
    wr(3'd0, 32'h00);
    wr(3'd1, 32'd2);
    wr(3'd3, 32'd10);
    wr(3'd2, st_time + 32'd2);
    wr(3'd0, 32'h15);
    clr_counts();
    for (int i = 0; i < 45; i++) tick(1);
    for (int i = 0; i < 3; i++) tick(0);
    chk("R3 periodic firings", 32'(n_evt0), 32'd5);
    chk("R4 periodic high clocks", 32'(n_hi0), 32'd10);
    chk("R11 ch1 untouched (power off)", 32'(n_evt1), 32'd0);

    // R2/R3/R4 single shot, length 3
    wr(3'd0, 32'h00);
    wr(3'd1, 32'd3);
    wr(3'd3, 32'd0);
    wr(3'd2, st_time + 32'd2);
    wr(3'd0, 32'h15);
    clr_counts();
    tick(0);
    chk("R2 no fire before start", 32'(evt[0]), 0);
    for (int i = 0; i < 20; i++) tick(1);
    for (int i = 0; i < 5; i++) tick(0);
    chk("R3 single shot firings", 32'(n_evt0), 32'd1);
    chk("R4 pulse width 3", 32'(n_hi0), 32'd3);

    // R5 acknowledged mode
    rd = 2'b01; tick(0); rd = '0;
    wr(3'd0, 32'h00);
    wr(3'd1, 32'd0);
    wr(3'd2, st_time + 32'd1);
    wr(3'd0, 32'h15);
    for (int i = 0; i < 3; i++) tick(1);
    for (int i = 0; i < 10; i++) tick(0);
    chk("R5 ack level held", 32'(sync[0]), 1);
    chk("R9 irq from mapped status", 32'(irq), 1);
    rd = 2'b01; tick(0); rd = '0;
    chk("R5 ack level cleared", 32'(sync[0]), 0);
    chk("R7 status cleared by read", 32'(status[0]), 0);

    // R10 power off: start in the past, period 1, no output
    wr(3'd0, 32'h0F);
    wr(3'd1, 32'd1);
    wr(3'd5, 32'd1);
    wr(3'd4, 32'd0);
    wr(3'd2, 32'd0);
    clr_counts();
    for (int i = 0; i < 20; i++) tick(1);
    chk("R10 ch0 no events", 32'(n_evt0), 0);
    chk("R10 ch1 no events", 32'(n_evt1), 0);

    // R6/R8 pin gating while events continue
    wr(3'd0, 32'h30);
    clr_counts();
    for (int i = 0; i < 6; i++) tick(1);
    chk("R6 strobes with pins off", 32'(n_evt1 > 0), 1);
    chk("R8 pins off", 32'(oe), 0);
    wr(3'd0, 32'h3F);
    loaded = 0; tick(0);
    chk("R8 not loaded hi-z", 32'(oe), 0);
    loaded = 1; tick(0);
    chk("R8 loaded drives", 32'(oe), 32'h3);

    tick(0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule